// File: doc/BRIEF.md
# Element-Width-Scaled Sign Extender

This block sign-extends packed elements held in a 64-bit operand. The operand is split into elements of 8, 16, 32 or 64 bits, and every element is handled on its own in the same cycle. A small field at the bottom of each element is sign-extended to fill the whole element. The op select picks one of three extend kinds, called byte, halfword and word.

Two modes set the field size. In scaled mode the field is a fixed fraction of the element width. Byte takes an eighth of the element, halfword a quarter and word a half. Fields can therefore shrink to a single bit, which turns each element into an all-ones or all-zero mask. In legacy mode the field is a fixed 8, 16 or 32 bits whatever the element width. If that field is not narrower than the element, the element passes through unchanged.

The result and an error flag are registered. They appear one clock after a valid strobe.

Top module: `sext_scaled_unit`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising edge) clears `out_valid`, `out_err` and `out_data` to zero at that edge.
- R2: `out_valid` equals the value `in_valid` had at the previous rising edge. `out_data` loads only on edges where `in_valid` is high and holds otherwise.
- R3: In scaled mode (`scaled_mode`=1), the byte op (`op_sel`=0) sign-extends the low EW/8 bits of each element. EW is the element width: `elem_width` 0/1/2/3 selects 8/16/32/64 bits.
- R4: In scaled mode, the halfword op (`op_sel`=1) sign-extends the low EW/4 bits of each element.
- R5: In scaled mode, the word op (`op_sel`=2) sign-extends the low EW/2 bits of each element. For example, with 16-bit elements it extends the low 8 bits.
- R6: A 1-bit field (scaled byte op, 8-bit elements) copies bit 0 of each byte into all 8 bits of that byte, giving 8'hFF or 8'h00.
- R7: The extended field is always taken from the least significant bits of the element.
- R8: In legacy mode (`scaled_mode`=0), the byte, halfword and word ops extend fields of 8, 16 and 32 bits, independent of the element width.
- R9: In legacy mode, if the field is equal to or wider than the element, the element is output unchanged.
- R10: `op_sel`=3 is illegal. For a valid strobe carrying it, the registered result is zero and `out_err` is high for exactly that one output cycle. `out_err` is low after any other strobe or no strobe.
- R11: Every element within the operand is extended independently, from its own bits only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input strobe |
| in_data | input | 64 | Packed source operand |
| op_sel | input | 2 | 0 byte, 1 halfword, 2 word, 3 illegal |
| elem_width | input | 2 | 0/1/2/3 selects 8/16/32/64-bit elements |
| scaled_mode | input | 1 | 1 scaled field size, 0 fixed legacy field size |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_data | output | 64 | Registered extended operand |
| out_err | output | 1 | Illegal op reported for this result |

## Verification
Every result of this block is due at the first rising edge after its stimulus. This covers the extended data, the valid flag, the error flag and the reset clearing. The bench drives each stimulus at a falling edge and compares outputs at the next falling edge, exactly one register stage later. Back-to-back table vectors also show that each result depends only on the stimulus one edge earlier. Hold behaviour and error clearing are checked on the cycle right after the strobe drops or a legal op follows.

// File: rtl/sext_pkg.sv
// Package: shared encodings and helpers for the scaled sign extender.
// Assumes a 64-bit datapath and element widths of 8, 16, 32 and 64 bits.
package sext_pkg;

    localparam int SX_DATA_W  = 64;
    localparam int SX_NUM_EW  = 4;
    localparam int SX_MIN_LOG = 3;   // log2 of the smallest element width
    localparam int SX_FLD_W   = 3;   // width of a field-size log2 value

    typedef enum logic [1:0] {
        OP_BYTE = 2'd0,
        OP_HALF = 2'd1,
        OP_WORD = 2'd2,
        OP_BAD  = 2'd3
    } ext_op_e;

    typedef enum logic [1:0] {
        EW_8  = 2'd0,
        EW_16 = 2'd1,
        EW_32 = 2'd2,
        EW_64 = 2'd3
    } elem_w_e;

    // Spread bit 0 of every byte over that byte (the 1-bit field case).
    function automatic logic [SX_DATA_W-1:0] lsb_fill_bytes(input logic [SX_DATA_W-1:0] v);
        logic [SX_DATA_W-1:0] r;
        for (int k = 0; k < SX_DATA_W / 8; k++) begin
            r[k*8 +: 8] = {8{v[k*8]}};
        end
        return r;
    endfunction

endpackage

// File: rtl/sext_field_ctrl.sv
// Module: sext_field_ctrl
// Turns op, element width and mode into the log2 size of the field to extend.
// Assumes the op encoding of sext_pkg; an illegal op yields a zero field log.
module sext_field_ctrl
    import sext_pkg::*;
(
    input  logic [1:0]          op_sel,
    input  logic [1:0]          elem_width,
    input  logic                scaled_mode,
    output logic [SX_FLD_W-1:0] fld_log,
    output logic                illegal
);

    // Decode the field size: scaled follows element width, legacy is fixed.
    always_comb begin
        illegal = (ext_op_e'(op_sel) == OP_BAD);
        if (illegal) begin
            fld_log = '0;
        end else if (scaled_mode) begin
            fld_log = SX_FLD_W'(elem_width) + SX_FLD_W'(op_sel);
        end else begin
            fld_log = SX_FLD_W'(SX_MIN_LOG) + SX_FLD_W'(op_sel);
        end
    end

    // R3: in scaled mode the field is always narrower than the selected element.
    always_comb begin
        if (scaled_mode && !illegal) begin
            p_scaled_field_r3: assert (int'(fld_log) < SX_MIN_LOG + int'(elem_width))
                else $error("scaled field not narrower than element");
        end
    end

endmodule

// File: rtl/sext_elem.sv
// Module: sext_elem
// Sign-extends the low 2**fld_log bits of one W-bit element.
// Assumes W is a power of two of at least 8; a field at least W wide passes through.
module sext_elem
    import sext_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]        din,
    input  logic [SX_FLD_W-1:0] fld_log,
    output logic [W-1:0]        dout
);

    localparam int LW = $clog2(W);

    logic [6:0]    span;
    logic [6:0]    sidx_full;
    logic [LW-1:0] sidx;
    logic          pass_thru;
    logic          sign_bit;

    // Locate the field's top bit and decide whether the element passes through.
    always_comb begin
        span      = 7'd1 << fld_log;
        sidx_full = span - 7'd1;
        sidx      = sidx_full[LW-1:0];
        pass_thru = (int'(fld_log) >= LW);
        sign_bit  = din[sidx];
    end

    // Keep bits inside the field and copy the sign bit into the rest.
    always_comb begin
        for (int j = 0; j < W; j++) begin
            if (pass_thru || (7'(j) < span)) begin
                dout[j] = din[j];
            end else begin
                dout[j] = sign_bit;
            end
        end
    end

endmodule

// File: rtl/sext_scaled_unit.sv
// Module: sext_scaled_unit (top)
// Packed-element sign extender with a scaled or fixed field size and one
// output register stage. Assumes a 64-bit operand and a synchronous active-low reset.
module sext_scaled_unit
    import sext_pkg::*;
#(
    parameter int DATA_W = SX_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [1:0]        op_sel,
    input  logic [1:0]        elem_width,
    input  logic              scaled_mode,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_err
);

    localparam int NUM_EW = SX_NUM_EW;

    logic [SX_FLD_W-1:0] fld_log;
    logic                illegal;
    logic [DATA_W-1:0]   cand [NUM_EW];
    logic [DATA_W-1:0]   result;

    sext_field_ctrl u_ctrl (
        .op_sel      (op_sel),
        .elem_width  (elem_width),
        .scaled_mode (scaled_mode),
        .fld_log     (fld_log),
        .illegal     (illegal)
    );

    // One lane array per element width; each element is extended on its own.
    for (genvar w = 0; w < NUM_EW; w++) begin : g_width
        localparam int EW = 8 << w;
        localparam int NE = DATA_W / EW;
        logic [DATA_W-1:0] lane_res;
        for (genvar e = 0; e < NE; e++) begin : g_elem
            sext_elem #(.W(EW)) u_elem (
                .din     (in_data[e*EW +: EW]),
                .fld_log (fld_log),
                .dout    (lane_res[e*EW +: EW])
            );
        end
        assign cand[w] = lane_res;
    end

    // Pick the lane array for the selected width, forcing zero on an illegal op.
    always_comb begin
        result = illegal ? '0 : cand[elem_width];
    end

    // Register valid, error and data; data loads only with a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_err   <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            out_err   <= in_valid && illegal;
            if (in_valid) begin
                out_data <= result;
            end
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_err && out_data == '0))
        else $error("reset did not clear outputs");

    p_valid_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid)
        else $error("valid not propagated");

    p_valid_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_data)))
        else $error("idle cycle changed outputs");

    p_err_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> (out_data == '0 && out_valid))
        else $error("error result not zero");

    p_err_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'd3) |=> out_err)
        else $error("illegal op not flagged");

    p_onebit_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && scaled_mode && op_sel == 2'd0 && elem_width == 2'd0)
        |=> out_data == lsb_fill_bytes($past(in_data)))
        else $error("1-bit field not spread to mask");

    p_legacy_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !scaled_mode && op_sel != 2'd3 && op_sel >= elem_width)
        |=> out_data == $past(in_data))
        else $error("wide legacy field did not pass element");

endmodule

// File: tb/sext_scaled_unit_tb.sv
module sext_scaled_unit_tb;

    typedef struct packed {
        logic [23:0] tag;
        logic [63:0] din;
        logic [1:0]  op;
        logic [1:0]  ew;
        logic        mode;
        logic [63:0] exp;
        logic        err;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{"R6 ", 64'h0102_0304_0506_0708, 2'd0, 2'd0, 1'b1, 64'hFF00_FF00_FF00_FF00, 1'b0},
        '{"R3 ", 64'h0001_0002_0003_FFFC, 2'd0, 2'd1, 1'b1, 64'h0001_FFFE_FFFF_0000, 1'b0},
        '{"R4 ", 64'h1237_00F8_ABC0_0009, 2'd1, 2'd1, 1'b1, 64'h0007_FFF8_0000_FFF9, 1'b0},
        '{"R5 ", 64'h1280_AA7F_00FF_FF01, 2'd2, 2'd1, 1'b1, 64'hFF80_007F_FFFF_0001, 1'b0},
        '{"R5 ", 64'h0000_0000_8000_0000, 2'd2, 2'd3, 1'b1, 64'hFFFF_FFFF_8000_0000, 1'b0},
        '{"R7 ", 64'hFFFF_FFF7_0000_0008, 2'd0, 2'd2, 1'b1, 64'h0000_0007_FFFF_FFF8, 1'b0},
        '{"R8 ", 64'h1234_5678_9ABC_DE80, 2'd0, 2'd3, 1'b0, 64'hFFFF_FFFF_FFFF_FF80, 1'b0},
        '{"R8 ", 64'h0080_7F7F_1201_00FF, 2'd0, 2'd1, 1'b0, 64'hFF80_007F_0001_FFFF, 1'b0},
        '{"R8 ", 64'h1234_8000_5678_7FFF, 2'd1, 2'd2, 1'b0, 64'hFFFF_8000_0000_7FFF, 1'b0},
        '{"R9 ", 64'hDEAD_BEEF_0123_4567, 2'd2, 2'd1, 1'b0, 64'hDEAD_BEEF_0123_4567, 1'b0},
        '{"R9 ", 64'h8001_7F80_FF00_1234, 2'd0, 2'd0, 1'b0, 64'h8001_7F80_FF00_1234, 1'b0},
        '{"R10", 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 2'd1, 1'b1, 64'h0000_0000_0000_0000, 1'b1},
        '{"R11", 64'h0302_0100_FFFE_FDFC, 2'd1, 2'd0, 1'b1, 64'hFFFE_0100_FFFE_0100, 1'b0},
        '{"R5 ", 64'h0F08_0770_8899_A55A, 2'd2, 2'd0, 1'b1, 64'hFFF8_0700_F8F9_05FA, 1'b0},
        '{"R4 ", 64'h1111_2222_3333_8001, 2'd1, 2'd3, 1'b1, 64'hFFFF_FFFF_FFFF_8001, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [63:0] in_data;
    logic [1:0]  op_sel;
    logic [1:0]  elem_width;
    logic        scaled_mode;
    logic        out_valid;
    logic [63:0] out_data;
    logic        out_err;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    sext_scaled_unit u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .op_sel      (op_sel),
        .elem_width  (elem_width),
        .scaled_mode (scaled_mode),
        .out_valid   (out_valid),
        .out_data    (out_data),
        .out_err     (out_err)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [63:0] d, input logic [1:0] op,
                         input logic [1:0] ew, input logic m);
        in_valid    = v;
        in_data     = d;
        op_sel      = op;
        elem_width  = ew;
        scaled_mode = m;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        drive(1'b0, '0, 2'd0, 2'd0, 1'b0);
        repeat (3) @(negedge clk);
        check("R1 reset valid", {63'd0, out_valid}, 64'd0);
        check("R1 reset data", out_data, 64'd0);
        check("R1 reset err", {63'd0, out_err}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: drive at a falling edge, compare at the next one.
        for (int i = 0; i < NV; i++) begin
            drive(1'b1, VECS[i].din, VECS[i].op, VECS[i].ew, VECS[i].mode);
            @(negedge clk);
            check($sformatf("%s vec%0d data", VECS[i].tag, i), out_data, VECS[i].exp);
            check($sformatf("R10 vec%0d err", i), {63'd0, out_err}, {63'd0, VECS[i].err});
            check($sformatf("R2 vec%0d valid", i), {63'd0, out_valid}, 64'd1);
        end

        // R2: no strobe -> valid drops and data holds the last result.
        drive(1'b0, 64'h5555_5555_5555_5555, 2'd0, 2'd0, 1'b1);
        @(negedge clk);
        check("R2 idle valid", {63'd0, out_valid}, 64'd0);
        check("R2 idle hold", out_data, VECS[NV-1].exp);

        // R10: error lasts one cycle, then clears on a legal op.
        drive(1'b1, 64'h1234_5678_9ABC_DEF0, 2'd3, 2'd2, 1'b0);
        @(negedge clk);
        check("R10 err set", {63'd0, out_err}, 64'd1);
        check("R10 err data", out_data, 64'd0);
        drive(1'b1, 64'h0000_0000_0000_00F0, 2'd1, 2'd0, 1'b1);
        @(negedge clk);
        check("R10 err clear", {63'd0, out_err}, 64'd0);
        check("R4 ew8 half", out_data, 64'h0000_0000_0000_0000);
        drive(1'b0, '0, 2'd0, 2'd0, 1'b0);
        @(negedge clk);
        check("R10 err idle", {63'd0, out_err}, 64'd0);

        // R11: one negative element among positives affects only itself.
        drive(1'b1, 64'h0000_0000_0000_8000, 2'd1, 2'd2, 1'b0);
        @(negedge clk);
        check("R11 isolated", out_data, 64'h0000_0000_FFFF_8000);

        // R1: reset in mid-stream clears a loaded result.
        drive(1'b1, 64'h0000_0000_0000_0080, 2'd0, 2'd3, 1'b0);
        @(negedge clk);
        check("R8 before reset", out_data, 64'hFFFF_FFFF_FFFF_FF80);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid reset data", out_data, 64'd0);
        check("R1 mid reset valid", {63'd0, out_valid}, 64'd0);
        rst_n = 1'b1;
        drive(1'b0, '0, 2'd0, 2'd0, 1'b0);
        @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule